// File: doc/BRIEF.md
# Scrolling Display Window Address Generator

This block produces the read addresses that a twelve-digit character display uses to fetch its contents from two separate buffers. The first is a 48-entry character-code buffer; the second is a 12-entry buffer of auxiliary symbols. Each buffer has its own circular base pointer. Digit position k (k = 0 for the leftmost digit, up to 11) reads base + k, and the sum wraps around the depth of that buffer. A 12-digit window therefore slides over a 48-character ring, and the auxiliary window rotates inside its own 12 entries.

Two decoded commands move the pointers. A set-address command loads both bases in one step. A shift command rotates the selected bases by one position, either left (window advances) or right (window moves back). The addresses come out in three forms: a flattened bus that carries every digit, a lookup port indexed by digit, and a free-running scan that visits one digit per clock. The buffer storage and the glyph generation belong to other blocks.

Top module: `scroll_window_addr`

## Requirements
- R1: While reset is held and after it is released with no command, both bases are zero. Digit k then shows main address k and auxiliary address k, and the scan digit is 0.
- R2: Main address of digit k is (mainBase + k) mod 48. It appears on digitMainBus bits [6k+5:6k] and on lookMainAddr when lookDigit = k.
- R3: Auxiliary address of digit k is (auxBase + k) mod 12. It appears on digitAuxBus bits [4k+3:4k] and on lookAuxAddr when lookDigit = k.
- R4: setAddr = 1 at a clock edge loads loadMain into the main base and loadAux into the auxiliary base. Both new values are visible after that edge.
- R5: A loaded main value of 48..63 is stored as value − 48. A loaded auxiliary value of 12..15 is stored as value − 12.
- R6: shiftEn = 1 with shiftRight = 0 adds one to each selected base, modulo its depth. shiftMain selects the main base and shiftAux selects the auxiliary base. From main base 0, digit 0 then shows 01H. From auxiliary base 0, digit 11 then shows 0.
- R7: shiftEn = 1 with shiftRight = 1 subtracts one from each selected base, modulo its depth. From zero, digit 0 then shows main 2FH and auxiliary BH, and digit 1 shows main 00H.
- R8: A base that a shift does not select keeps its value. A shift with neither base selected changes no address.
- R9: When setAddr and shiftEn are both 1 at the same edge, the load takes effect and the shift is ignored.
- R10: A lookDigit value of 12..15 is treated as lookDigit − 12.
- R11: scanDigit steps 0, 1, …, 11, 0 with one step per clock after reset. scanStart is 1 exactly when scanDigit is 0. scanMainAddr and scanAuxAddr give the addresses of digit scanDigit under the current bases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setAddr | input | 1 | Load both base pointers |
| shiftEn | input | 1 | Rotate the selected base pointers |
| shiftMain | input | 1 | Shift applies to the main base |
| shiftAux | input | 1 | Shift applies to the auxiliary base |
| shiftRight | input | 1 | 0 = left (advance), 1 = right (back) |
| loadMain | input | 6 | Main base value for setAddr |
| loadAux | input | 4 | Auxiliary base value for setAddr |
| lookDigit | input | 4 | Digit index for the lookup port |
| lookMainAddr | output | 6 | Main address of the looked-up digit |
| lookAuxAddr | output | 4 | Auxiliary address of the looked-up digit |
| digitMainBus | output | 72 | Main addresses of all digits, 6 bits each |
| digitAuxBus | output | 48 | Auxiliary addresses of all digits, 4 bits each |
| scanDigit | output | 4 | Digit currently visited by the scan |
| scanStart | output | 1 | High when the scan is on digit 0 |
| scanMainAddr | output | 6 | Main address of the scanned digit |
| scanAuxAddr | output | 4 | Auxiliary address of the scanned digit |

## Verification
The cases that are hardest to reach from the ports are the wrap seams. One is the main base near 47, where some digits of the window sit past the end of the ring and others do not. The other is the auxiliary base at 11, where every digit past the first wraps. A long run of left shifts walks both bases right through these seams, and directed right shifts from zero cross them in the other direction. Random loads of 48..63 and 12..15, random lookup indices of 12..15, and simultaneous load-and-shift commands cover the reduction and priority rules.

// File: rtl/sw_pkg.sv
package sw_pkg;
  typedef struct packed {
    logic loadBoth;
    logic stepMain;
    logic stepAux;
    logic toRight;
  } swStrobe_t;
endpackage

// File: rtl/sw_ctrl.sv
module sw_ctrl
  import sw_pkg::*;
#(
  parameter int DIGITS = 12,
  localparam int DW = $clog2(DIGITS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          setAddr,
  input  logic          shiftEn,
  input  logic          shiftMain,
  input  logic          shiftAux,
  input  logic          shiftRight,
  output swStrobe_t     strobe,
  output logic [DW-1:0] scanDigit,
  output logic          scanStart
);
  localparam logic [DW-1:0] LAST_DIGIT = DW'(DIGITS - 1);

  logic [DW-1:0] scanCnt;

  always_comb begin
    strobe          = '0;
    strobe.loadBoth = setAddr;
    strobe.stepMain = shiftEn && !setAddr && shiftMain;
    strobe.stepAux  = shiftEn && !setAddr && shiftAux;
    strobe.toRight  = shiftRight;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scanCnt <= '0;
    end else if (scanCnt == LAST_DIGIT) begin
      scanCnt <= '0;
    end else begin
      scanCnt <= scanCnt + 1'b1;
    end
  end

  assign scanDigit = scanCnt;
  assign scanStart = (scanCnt == '0);
endmodule

// File: rtl/sw_datapath.sv
module sw_datapath
  import sw_pkg::*;
#(
  parameter int MAIN_DEPTH = 48,
  parameter int AUX_DEPTH  = 12,
  parameter int DIGITS     = 12,
  localparam int MW = $clog2(MAIN_DEPTH),
  localparam int AW = $clog2(AUX_DEPTH),
  localparam int DW = $clog2(DIGITS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  swStrobe_t            strobe,
  input  logic [MW-1:0]        loadMain,
  input  logic [AW-1:0]        loadAux,
  input  logic [DW-1:0]        lookDigit,
  input  logic [DW-1:0]        scanDigit,
  output logic [MW-1:0]        mainBase,
  output logic [AW-1:0]        auxBase,
  output logic [DIGITS*MW-1:0] digitMainBus,
  output logic [DIGITS*AW-1:0] digitAuxBus,
  output logic [MW-1:0]        lookMainAddr,
  output logic [AW-1:0]        lookAuxAddr,
  output logic [MW-1:0]        scanMainAddr,
  output logic [AW-1:0]        scanAuxAddr
);
  localparam logic [MW:0]   MAIN_N    = (MW+1)'(MAIN_DEPTH);
  localparam logic [AW:0]   AUX_N     = (AW+1)'(AUX_DEPTH);
  localparam logic [DW:0]   DIG_N     = (DW+1)'(DIGITS);
  localparam logic [MW-1:0] MAIN_LAST = MW'(MAIN_DEPTH - 1);
  localparam logic [AW-1:0] AUX_LAST  = AW'(AUX_DEPTH - 1);

  logic [MW-1:0] mainPtr;
  logic [AW-1:0] auxPtr;
  logic [MW-1:0] mainLoadRed;
  logic [AW-1:0] auxLoadRed;
  logic [MW-1:0] mainAddrArr [DIGITS];
  logic [AW-1:0] auxAddrArr  [DIGITS];
  logic [DW-1:0] lookIdx;

  // Reduce out-of-range loads back into the ring (one subtraction suffices)
  always_comb begin
    mainLoadRed = ({1'b0, loadMain} >= MAIN_N) ? MW'({1'b0, loadMain} - MAIN_N) : loadMain;
    auxLoadRed  = ({1'b0, loadAux} >= AUX_N)   ? AW'({1'b0, loadAux} - AUX_N)   : loadAux;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mainPtr <= '0;
      auxPtr  <= '0;
    end else if (strobe.loadBoth) begin
      mainPtr <= mainLoadRed;
      auxPtr  <= auxLoadRed;
    end else begin
      if (strobe.stepMain) begin
        if (strobe.toRight) mainPtr <= (mainPtr == '0) ? MAIN_LAST : mainPtr - 1'b1;
        else                mainPtr <= (mainPtr == MAIN_LAST) ? '0 : mainPtr + 1'b1;
      end
      if (strobe.stepAux) begin
        if (strobe.toRight) auxPtr <= (auxPtr == '0) ? AUX_LAST : auxPtr - 1'b1;
        else                auxPtr <= (auxPtr == AUX_LAST) ? '0 : auxPtr + 1'b1;
      end
    end
  end

  // One wrapped adder per digit and per ring
  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [MW:0] mainSum;
    logic [AW:0] auxSum;
    always_comb begin
      mainSum = {1'b0, mainPtr} + (MW+1)'(g);
      auxSum  = {1'b0, auxPtr} + (AW+1)'(g % AUX_DEPTH);
      mainAddrArr[g] = (mainSum >= MAIN_N) ? MW'(mainSum - MAIN_N) : mainSum[MW-1:0];
      auxAddrArr[g]  = (auxSum >= AUX_N)   ? AW'(auxSum - AUX_N)   : auxSum[AW-1:0];
    end
    assign digitMainBus[g*MW +: MW] = mainAddrArr[g];
    assign digitAuxBus[g*AW +: AW]  = auxAddrArr[g];
  end

  assign lookIdx      = ({1'b0, lookDigit} >= DIG_N) ? DW'({1'b0, lookDigit} - DIG_N) : lookDigit;
  assign lookMainAddr = mainAddrArr[lookIdx];
  assign lookAuxAddr  = auxAddrArr[lookIdx];
  assign scanMainAddr = mainAddrArr[scanDigit];
  assign scanAuxAddr  = auxAddrArr[scanDigit];
  assign mainBase     = mainPtr;
  assign auxBase      = auxPtr;
endmodule

// File: rtl/scroll_window_addr.sv
module scroll_window_addr
  import sw_pkg::*;
#(
  parameter int MAIN_DEPTH = 48,
  parameter int AUX_DEPTH  = 12,
  parameter int DIGITS     = 12,
  localparam int MW = $clog2(MAIN_DEPTH),
  localparam int AW = $clog2(AUX_DEPTH),
  localparam int DW = $clog2(DIGITS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 setAddr,
  input  logic                 shiftEn,
  input  logic                 shiftMain,
  input  logic                 shiftAux,
  input  logic                 shiftRight,
  input  logic [MW-1:0]        loadMain,
  input  logic [AW-1:0]        loadAux,
  input  logic [DW-1:0]        lookDigit,
  output logic [MW-1:0]        lookMainAddr,
  output logic [AW-1:0]        lookAuxAddr,
  output logic [DIGITS*MW-1:0] digitMainBus,
  output logic [DIGITS*AW-1:0] digitAuxBus,
  output logic [DW-1:0]        scanDigit,
  output logic                 scanStart,
  output logic [MW-1:0]        scanMainAddr,
  output logic [AW-1:0]        scanAuxAddr
);
  swStrobe_t     strobe;
  logic [MW-1:0] mainBase;
  logic [AW-1:0] auxBase;

  sw_ctrl #(.DIGITS(DIGITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .setAddr(setAddr), .shiftEn(shiftEn),
    .shiftMain(shiftMain), .shiftAux(shiftAux), .shiftRight(shiftRight),
    .strobe(strobe), .scanDigit(scanDigit), .scanStart(scanStart)
  );

  sw_datapath #(.MAIN_DEPTH(MAIN_DEPTH), .AUX_DEPTH(AUX_DEPTH), .DIGITS(DIGITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadMain(loadMain), .loadAux(loadAux),
    .lookDigit(lookDigit), .scanDigit(scanDigit), .mainBase(mainBase), .auxBase(auxBase),
    .digitMainBus(digitMainBus), .digitAuxBus(digitAuxBus),
    .lookMainAddr(lookMainAddr), .lookAuxAddr(lookAuxAddr),
    .scanMainAddr(scanMainAddr), .scanAuxAddr(scanAuxAddr)
  );
endmodule

// File: rtl/sw_checker.sv
module sw_checker #(
  parameter int MAIN_DEPTH = 48,
  parameter int AUX_DEPTH  = 12,
  parameter int DIGITS     = 12,
  localparam int MW = $clog2(MAIN_DEPTH),
  localparam int AW = $clog2(AUX_DEPTH),
  localparam int DW = $clog2(DIGITS)
) (
  input logic          clk,
  input logic          rstN,
  input logic          setAddr,
  input logic          shiftEn,
  input logic          shiftMain,
  input logic          shiftAux,
  input logic          shiftRight,
  input logic [MW-1:0] loadMain,
  input logic [AW-1:0] loadAux,
  input logic [MW-1:0] mainBase,
  input logic [AW-1:0] auxBase,
  input logic [DW-1:0] scanDigit,
  input logic          scanStart
);
  assert_base_in_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    (int'(mainBase) < MAIN_DEPTH) && (int'(auxBase) < AUX_DEPTH));

  assert_load_both_R4: assert property (@(posedge clk) disable iff (!rstN)
    setAddr |=> (int'(mainBase) == int'($past(loadMain)) % MAIN_DEPTH)
             && (int'(auxBase) == int'($past(loadAux)) % AUX_DEPTH));

  assert_main_left_R6: assert property (@(posedge clk) disable iff (!rstN)
    (shiftEn && !setAddr && shiftMain && !shiftRight) |=>
      int'(mainBase) == (int'($past(mainBase)) + 1) % MAIN_DEPTH);

  assert_main_right_R7: assert property (@(posedge clk) disable iff (!rstN)
    (shiftEn && !setAddr && shiftMain && shiftRight) |=>
      int'(mainBase) == (int'($past(mainBase)) + MAIN_DEPTH - 1) % MAIN_DEPTH);

  assert_aux_step_R6_R7: assert property (@(posedge clk) disable iff (!rstN)
    (shiftEn && !setAddr && shiftAux) |=>
      int'(auxBase) == (int'($past(auxBase)) + ($past(shiftRight) ? AUX_DEPTH - 1 : 1)) % AUX_DEPTH);

  assert_unselected_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!setAddr && !(shiftEn && shiftMain)) |=> $stable(mainBase));

  assert_scan_wrap_R11: assert property (@(posedge clk) disable iff (!rstN)
    (int'(scanDigit) == DIGITS - 1) |=> scanStart && (scanDigit == '0));
endmodule

bind scroll_window_addr sw_checker #(
  .MAIN_DEPTH(MAIN_DEPTH), .AUX_DEPTH(AUX_DEPTH), .DIGITS(DIGITS)
) u_sw_checker (
  .clk(clk), .rstN(rstN), .setAddr(setAddr), .shiftEn(shiftEn),
  .shiftMain(shiftMain), .shiftAux(shiftAux), .shiftRight(shiftRight),
  .loadMain(loadMain), .loadAux(loadAux), .mainBase(mainBase), .auxBase(auxBase),
  .scanDigit(scanDigit), .scanStart(scanStart)
);

// File: tb/scroll_window_addr_bench.sv
`timescale 1ns/100ps
module scroll_window_addr_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        setAddr = 1'b0, shiftEn = 1'b0, shiftMain = 1'b0, shiftAux = 1'b0, shiftRight = 1'b0;
  logic [5:0]  loadMain = '0;
  logic [3:0]  loadAux = '0;
  logic [3:0]  lookDigit = '0;
  logic [5:0]  lookMainAddr, scanMainAddr;
  logic [3:0]  lookAuxAddr, scanAuxAddr, scanDigit;
  logic [71:0] digitMainBus;
  logic [47:0] digitAuxBus;
  logic        scanStart;

  int vecCount = 0;
  int failCount = 0;
  int mB = 0, aB = 0, expScan = 0;
  int cycles = 0;

  scroll_window_addr u_scroll_window_addr (
    .clk(clk), .rstN(rstN), .setAddr(setAddr), .shiftEn(shiftEn), .shiftMain(shiftMain),
    .shiftAux(shiftAux), .shiftRight(shiftRight), .loadMain(loadMain), .loadAux(loadAux),
    .lookDigit(lookDigit), .lookMainAddr(lookMainAddr), .lookAuxAddr(lookAuxAddr),
    .digitMainBus(digitMainBus), .digitAuxBus(digitAuxBus), .scanDigit(scanDigit),
    .scanStart(scanStart), .scanMainAddr(scanMainAddr), .scanAuxAddr(scanAuxAddr)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rstN) expScan <= 0;
    else       expScan <= (expScan + 1) % 12;
  end

  function automatic int expMain(int b, int d); return (b + d) % 48; endfunction
  function automatic int expAux(int b, int d);  return (b + d) % 12; endfunction

  task automatic chk(int act, int exp, string tag);
    vecCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkState(string tag);
    int li;
    for (int k = 0; k < 12; k++) begin
      chk(int'(digitMainBus[k*6 +: 6]), expMain(mB, k), $sformatf("R2 %s bus digit %0d", tag, k));
      chk(int'(digitAuxBus[k*4 +: 4]), expAux(aB, k), $sformatf("R3 %s bus digit %0d", tag, k));
    end
    li = (int'(lookDigit) >= 12) ? int'(lookDigit) - 12 : int'(lookDigit);
    chk(int'(lookMainAddr), expMain(mB, li), $sformatf("R2/R10 %s lookup %0d main", tag, lookDigit));
    chk(int'(lookAuxAddr), expAux(aB, li), $sformatf("R3/R10 %s lookup %0d aux", tag, lookDigit));
    chk(int'(scanDigit), expScan, $sformatf("R11 %s scanDigit", tag));
    chk(int'(scanStart), (expScan == 0) ? 1 : 0, $sformatf("R11 %s scanStart", tag));
    chk(int'(scanMainAddr), expMain(mB, expScan), $sformatf("R11 %s scan main", tag));
    chk(int'(scanAuxAddr), expAux(aB, expScan), $sformatf("R11 %s scan aux", tag));
  endtask

  // Called just after a falling edge; applies for one rising edge, checks at next falling edge
  task automatic cmd(logic sa, logic se, logic sm, logic sx, logic sr,
                     int lm, int la, int ld, string tag);
    setAddr = sa; shiftEn = se; shiftMain = sm; shiftAux = sx; shiftRight = sr;
    loadMain = 6'(lm); loadAux = 4'(la); lookDigit = 4'(ld);
    @(posedge clk);
    if (sa) begin
      mB = lm % 48; aB = la % 12;
    end else if (se) begin
      if (sm) mB = sr ? (mB + 47) % 48 : (mB + 1) % 48;
      if (sx) aB = sr ? (aB + 11) % 12 : (aB + 1) % 12;
    end
    @(negedge clk);
    setAddr = 0; shiftEn = 0;
    checkState(tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(int'(digitMainBus[5:0]), 0, "R1 reset held main digit0");
    rstN = 1'b1;
    @(negedge clk);
    checkState("R1 after reset");
    chk(int'(digitMainBus[11*6 +: 6]), 11, "R1 digit11 main");

    cmd(0, 1, 1, 0, 0, 0, 0, 0, "R6 main left");
    chk(int'(digitMainBus[5:0]), 1, "R6 digit0 shows 01H");
    chk(int'(digitAuxBus[3:0]), 0, "R8 aux untouched by main shift");
    cmd(0, 1, 1, 0, 1, 0, 0, 0, "R7 main right back");
    cmd(0, 1, 1, 1, 1, 0, 0, 1, "R7 both right from zero");
    chk(int'(digitMainBus[5:0]), 47, "R7 digit0 shows 2FH");
    chk(int'(digitMainBus[11:6]), 0, "R7 digit1 shows 00H");
    chk(int'(digitAuxBus[3:0]), 11, "R7 aux digit0 shows BH");
    cmd(1, 0, 0, 0, 0, 0, 0, 2, "R4 load zero");
    cmd(0, 1, 0, 1, 0, 0, 0, 11, "R6 aux left");
    chk(int'(digitAuxBus[11*4 +: 4]), 0, "R6 aux digit11 wraps to 0");
    chk(int'(digitMainBus[5:0]), 0, "R8 main untouched by aux shift");
    cmd(0, 1, 0, 0, 1, 0, 0, 3, "R8 shift none selected");
    cmd(1, 0, 0, 0, 0, 63, 15, 12, "R5 load 3FH/FH");
    chk(int'(digitMainBus[5:0]), 15, "R5 main 3FH reduces to 15");
    chk(int'(digitAuxBus[3:0]), 3, "R5 aux FH reduces to 3");
    cmd(1, 0, 0, 0, 0, 48, 12, 15, "R5 load 30H/CH");
    cmd(1, 1, 1, 1, 0, 40, 7, 13, "R9 load wins over shift");
    chk(int'(digitMainBus[5:0]), 40, "R9 main equals load");
    cmd(1, 0, 0, 0, 0, 47, 11, 4, "R4 load ring tops");
    for (int i = 0; i < 30; i++) cmd(0, 0, 0, 0, 0, 0, 0, i % 16, "R11 idle scan");
    for (int i = 0; i < 60; i++) cmd(0, 1, 1, 1, 0, 0, 0, i % 16, "R6 left walk");
    for (int i = 0; i < 60; i++) cmd(0, 1, 1, 1, 1, 0, 0, 15 - (i % 16), "R7 right walk");

    for (int i = 0; i < 800; i++) begin
      int r = $urandom_range(0, 9);
      logic sa = (r < 2);
      logic se = (r >= 1) && (r < 8);
      cmd(sa, se, 1'($urandom), 1'($urandom), 1'($urandom),
          $urandom_range(0, 63), $urandom_range(0, 15), $urandom_range(0, 15), "R2/R3 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    failCount++;
    $display("FAIL watchdog expired actual=%0d expected=<150000 cycles", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end
endmodule